// File: doc/BRIEF.md
# Dual-Channel Pulse Burst Generator

This block drives two independent pulse outputs. Each output alternates between a high phase and a low phase whose lengths are counted in whole time units. One unit is `TICK_DIV` clock cycles. The default of 25000 gives 100 µs at a 250 MHz clock. Each channel can either emit a fixed number of high/low cycles and then stop, or run without end.

All settings arrive as single-cycle writes on a command/parameter port. A write is an 8-bit code plus a 16-bit value. The codes select the high length, low length or pulse count of one channel, or the shared enable mask.

Software clears a channel's enable bit before it changes that channel's settings. It sets the bit again to start a fresh burst. Each channel has its own unit timer, which restarts when the channel is armed. The first unit after arming is therefore always full length.

Top module: `pwm_burst_gen`

## Requirements
- R1: While reset is held, and after it is released with no writes, every `pwm_out` and `burst_done` bit is 0.
- R2: The write codes are as follows. Code 0x10+2n sets the high length of channel n, and code 0x11+2n sets its low length. Code 0x14+n sets the pulse count of channel n. Code 0x1F sets the enable mask, where `cfg_data` bit n enables channel n. Lengths and counts are taken from the full 16-bit `cfg_data`.
- R3: A running channel holds `pwm_out` high for high-length × `TICK_DIV` cycles and then low for low-length × `TICK_DIV` cycles.
- R4: When an enable bit changes from 0 to 1, the channel reloads its counters. Its output is high from the second clock edge after the write is sampled.
- R5: With a pulse count N > 0, exactly N high/low cycles are produced. After that, `pwm_out` stays low and `burst_done` is 1 for as long as the channel stays enabled.
- R6: With a pulse count of 0, the high/low cycle repeats with no end and `burst_done` stays 0.
- R7: A length value of 0 is stored and used as 1 unit.
- R8: After the write edge that clears a channel's enable bit, `pwm_out` and `burst_done` of that channel are 0 from the next cycle on.
- R9: A write whose code is outside the map in R2 changes no setting. This includes codes that differ from a mapped code only in the upper bits.
- R10: Each channel's output depends only on its own settings and enable bit.
- R11: Suppose a disable write lands on the same edge as the last unit of a burst. Then `burst_done` never shows 1, and re-enabling the channel replays the full burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_valid | input | 1 | Write strobe for one command/parameter pair |
| cfg_code | input | CODE_W | Command code |
| cfg_data | input | DATA_W | Parameter value |
| pwm_out | output | NUM_CH | Pulse output per channel |
| burst_done | output | NUM_CH | Per channel, set once a finite burst has completed |

## Verification
Two events can fall on the same clock edge: the expiry of a burst's final low unit and a write that clears the channel's enable bit. The bench provokes this by issuing the disable write in the exact cycle it predicts for the last tick of a one-pulse burst. It judges the result in three ways. Both outputs must be low on the following cycles. `burst_done` must never rise. A later re-enable must produce the full burst again, sample by sample, against the bench's own waveform model.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;

  // Channel sequencing states
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // Command code map (per-channel codes are offsets from these bases)
  localparam int CODE_HI_BASE    = 'h10;  // + 2*n
  localparam int CODE_LO_BASE    = 'h11;  // + 2*n
  localparam int CODE_BURST_BASE = 'h14;  // + n
  localparam int CODE_ENABLE     = 'h1F;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int TICK_DIV = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      assign tick = 1'b1;
    end else begin : g_counted
      localparam int CNT_W = $clog2(TICK_DIV);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);
      localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             at_last;

      always_comb begin
        at_last = (cnt_q == CNT_LAST);
        if (clr || at_last) cnt_d = '0;
        else                cnt_d = cnt_q + CNT_ONE;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = at_last;
    end
  endgenerate

endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_burst_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 16,
  parameter int CODE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_valid,
  input  logic [CODE_W-1:0]              cfg_code,
  input  logic [DATA_W-1:0]              cfg_data,
  output logic [NUM_CH-1:0][DATA_W-1:0]  hi_len,
  output logic [NUM_CH-1:0][DATA_W-1:0]  lo_len,
  output logic [NUM_CH-1:0][DATA_W-1:0]  burst_len,
  output logic [NUM_CH-1:0]              en_mask
);

  localparam logic [DATA_W-1:0] LEN_MIN  = DATA_W'(1);
  localparam logic [CODE_W-1:0] EN_CODE  = CODE_W'(CODE_ENABLE);

  logic [DATA_W-1:0] len_wr;
  logic              hit_en;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] en_d;

  // Zero lengths are promoted to one unit at write time
  always_comb begin
    len_wr = (cfg_data == '0) ? LEN_MIN : cfg_data;
    hit_en = cfg_valid && (cfg_code == EN_CODE);
    en_d   = cfg_data[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (hit_en) en_q <= en_d;
  end

  assign en_mask = en_q;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic [CODE_W-1:0] HI_CODE = CODE_W'(CODE_HI_BASE + 2 * g);
      localparam logic [CODE_W-1:0] LO_CODE = CODE_W'(CODE_LO_BASE + 2 * g);
      localparam logic [CODE_W-1:0] BU_CODE = CODE_W'(CODE_BURST_BASE + g);

      logic              hit_hi, hit_lo, hit_bu;
      logic [DATA_W-1:0] hi_q, lo_q, bu_q;

      always_comb begin
        hit_hi = cfg_valid && (cfg_code == HI_CODE);
        hit_lo = cfg_valid && (cfg_code == LO_CODE);
        hit_bu = cfg_valid && (cfg_code == BU_CODE);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q <= LEN_MIN;
          lo_q <= LEN_MIN;
          bu_q <= '0;
        end else begin
          if (hit_hi) hi_q <= len_wr;
          if (hit_lo) lo_q <= len_wr;
          if (hit_bu) bu_q <= cfg_data;
        end
      end

      assign hi_len[g]    = hi_q;
      assign lo_len[g]    = lo_q;
      assign burst_len[g] = bu_q;

      // R7: stored lengths never hold zero
      p_len_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_q != '0) && (lo_q != '0));
    end
  endgenerate

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_burst_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TICK_DIV = 25000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] hi_len,
  input  logic [DATA_W-1:0] lo_len,
  input  logic [DATA_W-1:0] burst_len,
  output logic              pwm,
  output logic              done
);

  localparam logic [DATA_W-1:0] CNT_ONE = DATA_W'(1);
  localparam logic [DATA_W:0]   INC_ONE = (DATA_W + 1)'(1);

  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] per_q, per_d;
  logic [DATA_W-1:0] pulse_q, pulse_d;
  logic [DATA_W:0]   pulse_inc;
  logic              arm, tick, ce, finite, last_pulse;

  // Private timebase, restarted on arm so the first unit is full length
  pwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (arm),
    .tick  (tick)
  );

  always_comb begin
    arm        = en && (phase_q == PH_IDLE);
    finite     = (burst_len != '0);
    pulse_inc  = {1'b0, pulse_q} + INC_ONE;
    last_pulse = finite && (pulse_inc == {1'b0, burst_len});
    ce         = arm || tick || (!en && (phase_q != PH_IDLE));

    phase_d = phase_q;
    per_d   = per_q;
    pulse_d = pulse_q;

    if (!en) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_d = PH_HIGH;
          per_d   = hi_len;
          pulse_d = '0;
        end
        PH_HIGH: begin
          if (tick) begin
            if (per_q == CNT_ONE) begin
              phase_d = PH_LOW;
              per_d   = lo_len;
            end else begin
              per_d = per_q - CNT_ONE;
            end
          end
        end
        PH_LOW: begin
          if (tick) begin
            if (per_q == CNT_ONE) begin
              if (last_pulse) begin
                phase_d = PH_DONE;
              end else begin
                phase_d = PH_HIGH;
                per_d   = hi_len;
                if (finite) pulse_d = pulse_inc[DATA_W-1:0];
              end
            end else begin
              per_d = per_q - CNT_ONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      per_q   <= CNT_ONE;
      pulse_q <= '0;
    end else if (ce) begin
      phase_q <= phase_d;
      per_q   <= per_d;
      pulse_q <= pulse_d;
    end
  end

  // Enable gates the outputs directly so a disable takes effect at once
  assign pwm  = en && (phase_q == PH_HIGH);
  assign done = en && (phase_q == PH_DONE);

  // R4: a fresh enable enters the high phase with the high length loaded
  p_arm_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (phase_q == PH_HIGH) && (per_q == hi_len));

  // R8: a dropped enable returns the sequencer to idle
  p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> (phase_q == PH_IDLE));

  // R5: completed pulses never reach the programmed count while running
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (phase_q != PH_IDLE) && finite) |-> (pulse_q < burst_len));

  // R5: the finished state holds while enabled
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (phase_q == PH_DONE)) |=> (phase_q == PH_DONE));

  // R3: the unit down-counter is never zero in an active phase
  p_count_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_HIGH) || (phase_q == PH_LOW)) |-> (per_q != '0));

endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen
  import pwm_burst_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int TICK_DIV = 25000,
  parameter int DATA_W   = 16,
  parameter int CODE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [DATA_W-1:0] cfg_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] burst_done
);

  logic                          rst_core_n;
  logic [NUM_CH-1:0][DATA_W-1:0] hi_len;
  logic [NUM_CH-1:0][DATA_W-1:0] lo_len;
  logic [NUM_CH-1:0][DATA_W-1:0] burst_len;
  logic [NUM_CH-1:0]             en_mask;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pwm_cfg_regs #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .CODE_W (CODE_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg_valid (cfg_valid),
    .cfg_code  (cfg_code),
    .cfg_data  (cfg_data),
    .hi_len    (hi_len),
    .lo_len    (lo_len),
    .burst_len (burst_len),
    .en_mask   (en_mask)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pwm_channel #(
        .DATA_W   (DATA_W),
        .TICK_DIV (TICK_DIV)
      ) u_ch (
        .clk       (clk),
        .rst_n     (rst_core_n),
        .en        (en_mask[c]),
        .hi_len    (hi_len[c]),
        .lo_len    (lo_len[c]),
        .burst_len (burst_len[c]),
        .pwm       (pwm_out[c]),
        .done      (burst_done[c])
      );
    end
  endgenerate

endmodule

// File: tb/tb_pwm_burst_gen.sv
`timescale 1ns/1ps
module tb_pwm_burst_gen;

  localparam int NCH = 2;
  localparam int D   = 3;
  localparam int DW  = 16;
  localparam int CW  = 8;
  localparam int NV  = 5;
  localparam int WIN = 64;

  // Each row: en0, hi0, lo0, cnt0, en1, hi1, lo1, cnt1
  localparam int VEC [NV][8] = '{
    '{1, 2, 3, 2,  0, 1, 1, 0},
    '{0, 1, 1, 0,  1, 1, 1, 3},
    '{1, 1, 2, 0,  1, 3, 1, 1},
    '{1, 0, 0, 2,  1, 4, 2, 0},
    '{1, 5, 1, 1,  1, 2, 2, 2}
  };

  logic          clk;
  logic          rst_n;
  logic          cfg_valid;
  logic [CW-1:0] cfg_code;
  logic [DW-1:0] cfg_data;
  logic [NCH-1:0] pwm_out;
  logic [NCH-1:0] burst_done;

  int n_chk;
  int n_fail;

  pwm_burst_gen #(
    .NUM_CH   (NCH),
    .TICK_DIV (D),
    .DATA_W   (DW),
    .CODE_W   (CW)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_code   (cfg_code),
    .cfg_data   (cfg_data),
    .pwm_out    (pwm_out),
    .burst_done (burst_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Expected {done,out} k cycles after the arm edge
  function automatic logic [1:0] model(int k, int en, int hi, int lo, int b);
    int h, l, per;
    if (en == 0) return 2'b00;
    h   = (hi == 0) ? 1 : hi;
    l   = (lo == 0) ? 1 : lo;
    per = (h + l) * D;
    if (b != 0 && (k / per) >= b) return 2'b10;
    return {1'b0, ((k % per) < h * D)};
  endfunction

  // Called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [CW-1:0] c, input logic [DW-1:0] d);
    cfg_valid = 1'b1;
    cfg_code  = c;
    cfg_data  = d;
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_code  = '0;
    cfg_data  = '0;
  endtask

  task automatic prog(input int ch, input int hi, input int lo, input int b);
    wr(CW'(8'h10 + 2 * ch), DW'(hi));
    wr(CW'(8'h11 + 2 * ch), DW'(lo));
    wr(CW'(8'h14 + ch), DW'(b));
  endtask

  task automatic observe(input int n, input int e0, input int h0, input int l0, input int b0,
                         input int e1, input int h1, input int l1, input int b1,
                         input string tag);
    int bad [2];
    int fk [2];
    logic [1:0] fa [2];
    logic [1:0] fe [2];
    for (int c = 0; c < 2; c++) begin
      bad[c] = 0; fk[c] = -1; fa[c] = 2'b00; fe[c] = 2'b00;
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        logic [1:0] e;
        logic [1:0] a;
        e = (c == 0) ? model(k, e0, h0, l0, b0) : model(k, e1, h1, l1, b1);
        a = {burst_done[c], pwm_out[c]};
        if (a !== e) begin
          if (bad[c] == 0) begin
            fk[c] = k; fa[c] = a; fe[c] = e;
          end
          bad[c]++;
        end
      end
    end
    for (int c = 0; c < 2; c++)
      check(bad[c] == 0,
            $sformatf("%s ch%0d {done,out} first mismatch at cycle %0d", tag, c, fk[c]),
            int'(fa[c]), int'(fe[c]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    cfg_valid = 1'b0;
    cfg_code = '0;
    cfg_data = '0;
    repeat (3) @(negedge clk);
    check(pwm_out == '0 && burst_done == '0, "R1 outputs during reset",
          int'({burst_done, pwm_out}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm_out == '0 && burst_done == '0, "R1 outputs after reset release",
          int'({burst_done, pwm_out}), 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      wr(8'h1F, 16'h0000);
      prog(0, VEC[v][1], VEC[v][2], VEC[v][3]);
      prog(1, VEC[v][5], VEC[v][6], VEC[v][7]);
      wr(8'h1F, DW'(VEC[v][0] | (VEC[v][4] << 1)));
      observe(WIN, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
              VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7],
              $sformatf("R2 R3 R4 R5 R6 R7 R10 vector %0d", v));
    end

    // R9: unmapped codes leave settings and enable mask untouched
    wr(8'h1F, 16'h0000);
    prog(0, 2, 2, 1);
    wr(8'h9F, 16'h0003);
    wr(8'h16, 16'hFFFF);
    wr(8'h0E, 16'h0003);
    wr(8'h00, 16'h0003);
    @(negedge clk);
    check(pwm_out == '0 && burst_done == '0, "R9 no channel enabled by unmapped codes",
          int'({burst_done, pwm_out}), 0);
    wr(8'h1F, 16'h0001);
    observe(30, 1, 2, 2, 1, 0, 1, 1, 0, "R9 settings unchanged by unmapped codes");

    // R8: disable in the middle of a high phase
    wr(8'h1F, 16'h0000);
    prog(0, 4, 4, 0);
    wr(8'h1F, 16'h0001);
    observe(2, 1, 4, 4, 0, 0, 1, 1, 0, "R8 pre-disable");
    wr(8'h1F, 16'h0000);
    check(pwm_out[0] == 1'b0, "R8 output low right after disable", int'(pwm_out[0]), 0);
    repeat (8) @(negedge clk);
    check(pwm_out == '0 && burst_done == '0, "R8 output stays low while disabled",
          int'({burst_done, pwm_out}), 0);

    // R11: disable lands on the edge of the final tick
    prog(0, 1, 1, 1);
    wr(8'h1F, 16'h0001);
    observe(6, 1, 1, 1, 1, 0, 1, 1, 0, "R11 before coincident disable");
    wr(8'h1F, 16'h0000);
    check(pwm_out[0] == 1'b0 && burst_done[0] == 1'b0, "R11 no done after coincident disable",
          int'({burst_done[0], pwm_out[0]}), 0);
    repeat (4) @(negedge clk);
    check(burst_done == '0, "R11 done stays low", int'(burst_done), 0);
    wr(8'h1F, 16'h0001);
    observe(12, 1, 1, 1, 1, 0, 1, 1, 0, "R11 re-enable replays full burst");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule